// File: doc/BRIEF.md
# Pattern-Kicked Watchdog Timer

This block watches over a microprocessor by counting frame pulses in a binary counter with eleven stages. The processor must restart the counter often enough by writing a fixed bit pattern to one register address on a simple parallel write bus. An external reset input restarts the counter as well. The active-low alarm output is the inverse of the counter's top stage. It stays high for 1024 frame pulses after each restart.

If the processor stops restarting the counter, the counter keeps running and wraps around. The alarm output then repeats low and high phases of 1024 frame pulses each, instead of holding a latched flag. The frame-pulse input is sampled on the system clock. Each rising edge advances the counter by one. The frame-pulse input has to keep toggling for the watchdog to work.

Top module: `kick_watchdog`

## Requirements
- R1: After the synchronous system reset `rst`, `wd_alarm_n` is 1 and the counter is zero, so exactly 1024 frame-pulse rising edges pass before `wd_alarm_n` first goes to 0.
- R2: The counter advances by one for each rising edge of `frame_pulse` seen on `clk`. A `frame_pulse` held high for several clocks counts once.
- R3: After any clear, `wd_alarm_n` stays 1 for exactly 1024 rising edges and goes to 0 on the 1024th edge.
- R4: With no clear, `wd_alarm_n` stays 0 for exactly 1024 rising edges and then returns to 1. The 2048-edge cycle repeats with no end.
- R5: A cycle with `ext_rst` at 1 clears the counter to zero, even when a frame-pulse edge arrives in the same cycle.
- R6: A bus write with `bus_we`=1, `bus_addr`=WD_ADDR (default 4'h3) and `bus_wdata[4:0]`=5'b01010 clears the counter, whatever the value of `bus_wdata[7:5]`.
- R7: A write to WD_ADDR whose `bus_wdata[4:0]` differs from 5'b01010 leaves the counter unchanged.
- R8: A write of the restart pattern to any address other than WD_ADDR leaves the counter unchanged.
- R9: A valid restart write in the same cycle as a frame-pulse edge leaves the counter at zero, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ext_rst | input | 1 | External watchdog restart, active high, synchronous |
| frame_pulse | input | 1 | Frame pulse; each rising edge advances the counter |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (4) | Bus write address |
| bus_wdata | input | DATA_W (8) | Bus write data |
| wd_alarm_n | output | 1 | Active-low watchdog alarm, the inverse of the counter's top stage |

## Verification
On every cycle, the assertions check how the counter moves. It clears after a restart, an external reset or a system reset. It holds when there is no edge. It steps by exactly one on an edge. They also check that a frame-pulse edge never fires on two cycles in a row, and that a wrong pattern or a wrong address never produces a restart. The length of the high and low phases, the wrap into a repeating alarm, and the full sweep of data patterns against the restart decode can only be shown by the bench's scenarios. The bench counts edges until the alarm output changes.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int unsigned KEY_W   = 5;
  localparam logic [KEY_W-1:0] KEY_DEFAULT = 5'b01010;
endpackage

// File: rtl/wd_edge_detect.sv
module wd_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise_tick
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise_tick = level_in & ~level_q;

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> !rise_tick);
endmodule

// File: rtl/wd_kick_decode.sv
module wd_kick_decode
  import wd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] WD_ADDR = 4'h3,
  parameter logic [KEY_W-1:0]  KEY     = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              kick
);
  logic addr_hit;
  logic key_hit;

  assign addr_hit = we && (addr == WD_ADDR);
  assign key_hit  = (wdata[KEY_W-1:0] == KEY);
  assign kick     = addr_hit && key_hit;

  // R7
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[KEY_W-1:0] != KEY) |-> !kick);
  // R8
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr != WD_ADDR) |-> !kick);
endmodule

// File: rtl/wd_stage_counter.sv
module wd_stage_counter #(
  parameter int unsigned STAGES = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  output logic [STAGES-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (tick)   count <= count + 1'b1;
  end

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> $stable(count));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned STAGES  = 11,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] WD_ADDR = 4'h3,
  parameter logic [KEY_W-1:0]  KEY     = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst,
  input  logic              frame_pulse,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wd_alarm_n
);
  localparam int unsigned TOP = STAGES - 1;

  logic              tick;
  logic              kick;
  logic              clr;
  logic [STAGES-1:0] count;

  wd_edge_detect u_edge (
    .clk       (clk),
    .rst       (rst),
    .level_in  (frame_pulse),
    .rise_tick (tick)
  );

  wd_kick_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WD_ADDR (WD_ADDR),
    .KEY     (KEY)
  ) u_decode (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .kick  (kick)
  );

  assign clr = kick | ext_rst;

  wd_stage_counter #(.STAGES(STAGES)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .tick  (tick),
    .count (count)
  );

  assign wd_alarm_n = ~count[TOP];

  // R5
  ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> wd_alarm_n);
  // R1
  reset_high_chk: assert property (@(posedge clk)
    rst |=> wd_alarm_n);
endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;
  localparam logic [3:0] WDA = 4'h3;
  localparam logic [4:0] KEYV = 5'b01010;

  logic clk = 1'b0;
  logic rst, ext_rst, frame_pulse, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic wd_alarm_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  kick_watchdog u_kick_watchdog (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .frame_pulse(frame_pulse),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wd_alarm_n(wd_alarm_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s wd_alarm_n actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s edges actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fp, input logic we, input logic [3:0] a,
                     input logic [7:0] d, input logic er);
    frame_pulse = fp; bus_we = we; bus_addr = a; bus_wdata = d; ext_rst = er;
    @(negedge clk);
    cycles++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 4'h0, 8'h00, 1'b0);
      cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
    end
  endtask

  task automatic kick();
    cyc(1'b0, 1'b1, WDA, {3'b000, KEYV}, 1'b0);
  endtask

  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    while (wd_alarm_n !== lvl && n < 3000) begin
      ticks(1);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; ext_rst = 1'b0; frame_pulse = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", wd_alarm_n, 1'b1);
    edges_until(1'b0, n); check_n("R1", n, 1024);
    edges_until(1'b1, n); check_n("R4", n, 1024);
    edges_until(1'b0, n); check_n("R4", n, 1024);
    edges_until(1'b1, n); check_n("R4", n, 1024);

    // R2: held high counts once
    kick();
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 4'h0, 8'h00, 1'b0);
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
    ticks(1022);
    check("R2", wd_alarm_n, 1'b1);
    ticks(1);
    check("R2", wd_alarm_n, 1'b0);

    // R3 after a kick in the low phase
    kick();
    check("R3", wd_alarm_n, 1'b1);
    edges_until(1'b0, n); check_n("R3", n, 1024);

    // R5 external reset, alone and with an edge
    ticks(300);
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
    edges_until(1'b0, n); check_n("R5", n, 1024);
    ticks(200);
    cyc(1'b1, 1'b0, 4'h0, 8'h00, 1'b1);
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
    edges_until(1'b0, n); check_n("R5", n, 1024);

    // R9 kick with an edge in the same cycle
    ticks(100);
    cyc(1'b1, 1'b1, WDA, {3'b101, KEYV}, 1'b0);
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
    edges_until(1'b0, n); check_n("R9", n, 1024);

    // R6/R7 sweep of the low five bits, upper bits varied
    for (int lo = 0; lo < 32; lo++) begin
      kick(); ticks(1023);
      cyc(1'b0, 1'b1, WDA, {3'(lo % 8), 5'(lo)}, 1'b0);
      ticks(1);
      if (lo == 10) check("R6", wd_alarm_n, 1'b1);
      else          check("R7", wd_alarm_n, 1'b0);
    end
    // R6 every upper-bit value with the key
    for (int up = 0; up < 8; up++) begin
      kick(); ticks(1023);
      cyc(1'b0, 1'b1, WDA, {3'(up), KEYV}, 1'b0);
      ticks(1);
      check("R6", wd_alarm_n, 1'b1);
    end
    // R8 key written to the other addresses
    for (int a = 0; a < 16; a++) begin
      if (a == int'(WDA)) continue;
      kick(); ticks(1023);
      cyc(1'b0, 1'b1, 4'(a), {3'b000, KEYV}, 1'b0);
      ticks(1);
      check("R8", wd_alarm_n, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule